// File: doc/BRIEF.md
# Pen-Down Request with Conversion Hold

This block drives the active-low pen-down request line that a touch controller raises to its host. A raw touch-detect level comes in from the analog front end, passes through a two-flop synchronizer, and is then qualified by three things: the converter's operating mode, a converter-busy flag and a request-disable bit. Detection runs only when the converter is in master mode (mode code 2'b11). In every other mode the line is forced high and the captured touch state is cleared.

While a conversion is in progress, detection is suspended and the captured touch state is frozen. A release that occurs during a conversion therefore keeps the line low until the converter returns to idle. A touch that begins during a conversion is likewise reported only once the converter is idle. When the converter is idle, changes in touch are reported as soon as the synchronizer delivers them. The disable bit gates the output without clearing the captured state.

All pins are plain control and status levels, with no data stream, so the block has no valid/ready handshake.

Top module: `pen_req_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pen_req_n is 1 whatever touch_raw is, because the captured touch state resets to "not touched".
- R2: In master mode (conv_mode == 2'b11) with conv_busy = 0 and pen_disable = 0, a rise of touch_raw (1 = touched) driven between clock edges leaves pen_req_n at 1 after the next two rising edges and drives it to 0 after the third.
- R3: Whenever pen_disable is 1, pen_req_n is 1 in the same cycle, with no clock edge needed. When pen_disable returns to 0, the captured touch state shows again.
- R4: When touch_raw is 0 and has been 0 for at least three edges, pen_req_n rests at 1.
- R5: In any mode other than 2'b11 (00, 01, 10), pen_req_n is 1 in the same cycle and the captured state is cleared. After a return to 2'b11 with the converter idle and the touch held, pen_req_n goes to 0 after one rising edge.
- R6: A release of touch_raw in idle master mode drives pen_req_n back to 1 after the third rising edge, with the same latency as R2.
- R7: While conv_busy is 1 in master mode, pen_req_n does not change. A release seen during the conversion appears at the first rising edge after conv_busy returns to 0.
- R8: A touch that begins while conv_busy is 1 leaves pen_req_n at 1 until the first rising edge after conv_busy returns to 0, and drives it to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_raw | input | 1 | Unsynchronized touch level, 1 = panel touched |
| pen_disable | input | 1 | 1 = request output disabled (held high) |
| conv_mode | input | 2 | Converter mode, 2'b11 = master mode |
| conv_busy | input | 1 | 1 = a conversion is in progress |
| pen_req_n | output | 1 | Active-low pen-down request |

## Verification
If the captured touch state is wrong, it appears on pen_req_n no later than one edge after the converter is idle in master mode. The bench probes those windows. It holds the line through long conversions while the touch changes underneath, then checks the exact edge at which the converter's return to idle releases the deferred value. A wrong synchronizer depth shows as a one-edge shift in the R2 and R6 latency checks. A clear or gate that fails to act shows as a low line in a non-master mode, or while disabled, in the same cycle.

// File: rtl/pen_req_pkg.sv
package pen_req_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 2'b00,
    MODE_AUX1   = 2'b01,
    MODE_AUX2   = 2'b10,
    MODE_MASTER = 2'b11
  } conv_mode_e;
  localparam logic [MODE_W-1:0] MASTER_CODE = MODE_MASTER;
endpackage

// File: rtl/pen_touch_sync.sv
module pen_touch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[LAST];
endmodule

// File: rtl/pen_detect_qual.sv
module pen_detect_qual
  import pen_req_pkg::*;
#(
  parameter int                    MW          = MODE_W,
  parameter logic [MODE_W-1:0]     MASTER      = MASTER_CODE
) (
  input  logic [MW-1:0] conv_mode,
  input  logic          conv_busy,
  input  logic          pen_disable,
  output logic          sample_en,
  output logic          clear_state,
  output logic          req_allow
);
  logic is_master;

  always_comb begin
    is_master   = (conv_mode == MASTER);
    sample_en   = is_master && !conv_busy;
    clear_state = !is_master;
    req_allow   = is_master && !pen_disable;
  end
endmodule

// File: rtl/pen_hold_reg.sv
module pen_hold_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_state,
  input  logic sample_en,
  input  logic touch_s,
  output logic touch_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           touch_held <= 1'b0;
    else if (clear_state) touch_held <= 1'b0;
    else if (sample_en)   touch_held <= touch_s;
  end
endmodule

// File: rtl/pen_req_ctrl.sv
module pen_req_ctrl
  import pen_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_raw,
  input  logic              pen_disable,
  input  logic [MODE_W-1:0] conv_mode,
  input  logic              conv_busy,
  output logic              pen_req_n
);
  logic touch_s;
  logic sample_en;
  logic clear_state;
  logic req_allow;
  logic touch_held;

  pen_touch_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (touch_raw),
    .d_sync  (touch_s)
  );

  pen_detect_qual #(.MW(MODE_W), .MASTER(MASTER_CODE)) qual_i (
    .conv_mode   (conv_mode),
    .conv_busy   (conv_busy),
    .pen_disable (pen_disable),
    .sample_en   (sample_en),
    .clear_state (clear_state),
    .req_allow   (req_allow)
  );

  pen_hold_reg hold_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_state (clear_state),
    .sample_en   (sample_en),
    .touch_s     (touch_s),
    .touch_held  (touch_held)
  );

  assign pen_req_n = ~(touch_held & req_allow);
endmodule

// File: rtl/pen_req_checker.sv
module pen_req_checker
  import pen_req_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              touch_s,
  input logic              pen_disable,
  input logic [MODE_W-1:0] conv_mode,
  input logic              conv_busy,
  input logic              pen_req_n
);
  logic in_master;
  assign in_master = (conv_mode == MASTER_CODE);

  assert_disable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pen_disable |-> pen_req_n);

  assert_mode_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_master |-> pen_req_n);

  assert_fall_needs_touch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pen_req_n) |-> $past(touch_s));

  assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_master && $past(in_master) && !$past(conv_busy) && !$past(touch_s)) |-> pen_req_n);

  assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(conv_busy) && $past(in_master) && in_master && !pen_disable && !$past(pen_disable))
      |-> $stable(pen_req_n));
endmodule

bind pen_req_ctrl pen_req_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .touch_s     (touch_s),
  .pen_disable (pen_disable),
  .conv_mode   (conv_mode),
  .conv_busy   (conv_busy),
  .pen_req_n   (pen_req_n)
);

// File: tb/pen_req_ctrl_tb.sv
module pen_req_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       touch_raw = 1'b0;
  logic       pen_disable = 1'b0;
  logic [1:0] conv_mode = 2'b11;
  logic       conv_busy = 1'b0;
  logic       pen_req_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pen_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .touch_raw(touch_raw), .pen_disable(pen_disable),
    .conv_mode(conv_mode), .conv_busy(conv_busy), .pen_req_n(pen_req_n)
  );

  // row: {req, touch, disable, mode[1:0], busy, expected pen_req_n}
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {4'd4, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1},  // R4 idle untouched
    {4'd2, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0},  // R2 touch
    {4'd3, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1},  // R3 disabled
    {4'd3, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0},  // R3 re-enabled
    {4'd7, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0},  // R7 conversion starts
    {4'd7, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0},  // R7 release hidden
    {4'd7, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1},  // R7 shown at idle
    {4'd8, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1},  // R8 touch hidden
    {4'd8, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0},  // R8 shown at idle
    {4'd5, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1},  // R5 mode 10
    {4'd5, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1},  // R5 mode 01
    {4'd5, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1},  // R5 mode 00
    {4'd5, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0},  // R5 back to master
    {4'd6, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1}   // R6 release idle
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (pen_req_n !== exp) begin
      n_fails++;
      $display("FAIL %s: pen_req_n=%b expected %b at %0t", req, pen_req_n, exp, $time);
    end
  endtask

  initial begin
    // R1: reset with touch present
    touch_raw = 1'b1;
    step(3);
    check("R1", 1'b1);
    rst_n = 1'b1;
    step(0);
    check("R1", 1'b1);
    touch_raw = 1'b0;
    step(4);

    // table walk
    for (int i = 0; i < NV; i++) begin
      touch_raw   = VEC[i][5];
      pen_disable = VEC[i][4];
      conv_mode   = VEC[i][3:2];
      conv_busy   = VEC[i][1];
      step(5);
      check($sformatf("R%0d vec%0d", VEC[i][9:6], i), VEC[i][0]);
    end

    // R2 exact latency
    touch_raw = 1'b1;
    step(2);
    check("R2 after 2 edges", 1'b1);
    step(1);
    check("R2 after 3 edges", 1'b0);

    // R3 same-cycle gating
    pen_disable = 1'b1;
    #1;
    check("R3 same cycle", 1'b1);
    @(negedge clk);
    pen_disable = 1'b0;
    #1;
    check("R3 release same cycle", 1'b0);
    @(negedge clk);

    // R6 exact latency
    touch_raw = 1'b0;
    step(2);
    check("R6 after 2 edges", 1'b0);
    step(1);
    check("R6 after 3 edges", 1'b1);

    // R7 long conversion, deferred release on exact edge
    touch_raw = 1'b1;
    step(4);
    conv_busy = 1'b1;
    step(1);
    touch_raw = 1'b0;
    step(40);
    check("R7 held low in conversion", 1'b0);
    conv_busy = 1'b0;
    #1;
    check("R7 no change before edge", 1'b0);
    step(1);
    check("R7 high at first idle edge", 1'b1);

    // R8 touch during conversion, exact edge
    conv_busy = 1'b1;
    touch_raw = 1'b1;
    step(20);
    check("R8 hidden in conversion", 1'b1);
    conv_busy = 1'b0;
    step(1);
    check("R8 low at first idle edge", 1'b0);

    // R5 same-cycle forcing and clear on return
    conv_mode = 2'b01;
    #1;
    check("R5 same cycle", 1'b1);
    step(2);
    conv_mode = 2'b11;
    #1;
    check("R5 cleared on return", 1'b1);
    step(1);
    check("R5 recapture after one edge", 1'b0);

    // R4 rest high
    touch_raw = 1'b0;
    step(10);
    check("R4 rest", 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule